// File: doc/BRIEF.md
# Host Port Slave with Strap-Selected Acknowledge

This block lets an external host read and write the memory behind it through a multiplexed address/data bus. The host handshake is asynchronous. The host drives chip select, an address latch strobe, and separate read and write strobes. It then waits on one acknowledge line before it ends each strobe. The data path is 16 bits wide or 8 bits wide, chosen by a pin. In 8-bit mode a word moves as two byte transfers, low byte first.

On the chip side the block has a single request/grant memory port. A request stays up until the memory returns a one-cycle grant. The port has a one-entry write buffer and a one-entry read buffer. A host access is allowed to complete only when the buffer state permits it. Two strap inputs, sampled once after reset, set the polarity of the acknowledge line and its starting protocol. The two protocols are a pulse that signals completion and a ready level that signals waiting. A small configuration register, reached with a select pin, lets the host change the protocol and turn on address auto-increment.

The port also works out how the host supplies addresses. If the host pulses the latch strobe, the address is taken from that pulse. If the first write in a chip-select sequence arrives with no latch pulse, that write carries the address.

Top module: `hport_slave`

## Requirements
- R1: The acknowledge polarity and config bit 6 are sampled from `strap_pol_i`/`strap_ack_i` on the first clock after reset. Bit 6 is 1 when the two straps are equal and 0 when they differ. Bit 7 resets to 0. The polarity reads back as config bit 5. Strap changes after that first clock have no effect.
- R2: ACK mode is config bit 6 = 0. In this mode `hack_o` sits at its inactive level (the inverse of the polarity) and goes active only while a strobe is up and the access may complete.
- R3: Ready mode is config bit 6 = 1. In this mode `hack_o` sits at the ready level (equal to the polarity) and drops to the inverse level while a strobe is up and the access must wait.
- R4: A memory read completes only when the read buffer holds valid data and the write buffer is empty. A read of a missing word waits for the memory grant.
- R5: A data write completes only when the write buffer is not full. A write that arrives while an earlier word is still waiting for its grant is held off.
- R6: A rising address-latch strobe inside chip select loads the address from `had_i` and selects latch mode (config bit 4 = 0).
- R7: If the first strobe after chip select rises is a write and no latch pulse came first, that write loads the address and selects address-cycle mode (config bit 4 = 1). Later writes in the same sequence are data.
- R8: With config bit 0 set, the address increments after each complete word read or written. With bit 0 clear, the address stays the same.
- R9: With `h16_i` = 0, a word moves as two byte transfers on `had_i[7:0]`/`had_o[7:0]`, low byte first. The word reaches memory only after the high byte.
- R10: Each word uses exactly one memory cycle. `mem_req_o`, its address, its direction and its write data stay stable until `mem_gnt_i`.
- R11: Config writes change only bits 7, 6 and 0, while bits 5 and 4 are read-only. With bit 7 set, acknowledge comes one clock later than with bit 7 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_pol_i | input | 1 | Acknowledge polarity strap (1 = active high) |
| strap_ack_i | input | 1 | Acknowledge protocol strap |
| hcs_i | input | 1 | Host chip select, active high |
| hale_i | input | 1 | Host address latch strobe |
| hwr_i | input | 1 | Host write strobe |
| hrd_i | input | 1 | Host read strobe |
| hcfg_i | input | 1 | Selects the configuration register instead of memory |
| h16_i | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| had_i | input | 16 | Multiplexed address/data from the host |
| had_o | output | 16 | Read data toward the host |
| had_oe_o | output | 1 | Bus drive enable during a read |
| hack_o | output | 1 | Acknowledge / ready line |
| mem_req_o | output | 1 | Memory request, held until grant |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with grant |
| mem_gnt_i | input | 1 | One-cycle memory grant |

## Verification
The assertions assume a well-behaved host and memory. The host raises at most one of read and write at a time. It holds `had_i`, `hcfg_i` and `h16_i` steady while a strobe or latch pulse is up. After dropping a strobe, it stays idle for several clocks before the next one. The memory grants only while a request is pending, and only for one clock. The stimulus keeps these rules by spacing every host phase a fixed number of clocks apart and by using a memory model that grants after a set latency and then clears the grant.

// File: rtl/hport_pkg.sv
package hport_pkg;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = BUS_W / 2;

  // config bit positions; 7:6 form the acknowledge control pair
  localparam int CFG_AUTOINC = 0;
  localparam int CFG_ACCMODE = 4;
  localparam int CFG_POL     = 5;
  localparam int CFG_READY   = 6;
  localparam int CFG_LATE    = 7;

  typedef struct packed {
    logic late;
    logic ready;
  } ack_cfg_t;
endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/hport_ack.sv
module hport_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pol_i,
  input  logic ready_mode_i,
  input  logic late_i,
  input  logic strobe_i,
  input  logic done_i,
  output logic hack_o
);
  logic done_d_q;
  logic ok, act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_d_q <= 1'b0;
    else         done_d_q <= done_i;
  end

  always_comb begin
    ok  = late_i ? (done_i & done_d_q) : done_i;
    act = ready_mode_i ? ~(strobe_i & ~ok) : (strobe_i & ok);
    hack_o = pol_i ? act : ~act;
  end
endmodule

// File: rtl/hport_mem_if.sv
module hport_mem_if #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              rd_start_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              wbuf_full_o,
  output logic              rd_pend_o,
  output logic              rd_gnt_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i
);
  logic              full_q, rd_q;
  logic [ADDR_W-1:0] waddr_q, raddr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      rd_q    <= 1'b0;
      waddr_q <= '0;
      raddr_q <= '0;
      wdata_q <= '0;
    end else begin
      if (mem_gnt_i && full_q)       full_q <= 1'b0;
      else if (mem_gnt_i && rd_q)    rd_q   <= 1'b0;
      if (push_i) begin
        full_q  <= 1'b1;
        waddr_q <= push_addr_i;
        wdata_q <= push_data_i;
      end
      if (rd_start_i) begin
        rd_q    <= 1'b1;
        raddr_q <= rd_addr_i;
      end
    end
  end

  // writes drain first; a read is only started with the write buffer empty
  always_comb begin
    wbuf_full_o = full_q;
    rd_pend_o   = rd_q;
    rd_gnt_o    = mem_gnt_i & rd_q & ~full_q;
    mem_req_o   = full_q | rd_q;
    mem_we_o    = full_q;
    mem_addr_o  = full_q ? waddr_q : raddr_q;
    mem_wdata_o = wdata_q;
  end
endmodule

// File: rtl/hport_slave.sv
module hport_slave
  import hport_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_pol_i,
  input  logic              strap_ack_i,
  input  logic              hcs_i,
  input  logic              hale_i,
  input  logic              hwr_i,
  input  logic              hrd_i,
  input  logic              hcfg_i,
  input  logic              h16_i,
  input  logic [BUS_W-1:0]  had_i,
  output logic [BUS_W-1:0]  had_o,
  output logic              had_oe_o,
  output logic              hack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BUS_W-1:0]  mem_wdata_o,
  input  logic [BUS_W-1:0]  mem_rdata_i,
  input  logic              mem_gnt_i
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] sync_s;
  logic cs_s, ale_s, wr_s, rd_s;
  logic cs_q, ale_q, wr_q, rd_q;
  logic cs_rise, ale_rise, wr_fall, rd_fall;
  logic wr_act, rd_act, wr_word, wr_push, rd_start;
  logic [BUS_W-1:0] wr_data, cfg_val;

  logic              init_q, pol_q, acc_mode_q, autoinc_q;
  ack_cfg_t          ack_q;
  logic              seq_first_q, done_q, acc_cfg_q, byte_hi_q, rbuf_valid_q;
  logic [BYTE_W-1:0] lo_stage_q;
  logic [BUS_W-1:0]  rbuf_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wbuf_full, rd_pend, rd_gnt;

  hport_sync #(.W(NSYNC)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hcs_i, hale_i, hwr_i, hrd_i}),
    .q_o   (sync_s)
  );

  assign {cs_s, ale_s, wr_s, rd_s} = sync_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {cs_q, ale_q, wr_q, rd_q} <= '0;
    else         {cs_q, ale_q, wr_q, rd_q} <= sync_s;
  end

  always_comb begin
    cs_rise  = cs_s & ~cs_q;
    ale_rise = ale_s & ~ale_q & cs_s;
    wr_fall  = wr_q & ~wr_s;
    rd_fall  = rd_q & ~rd_s;
    wr_act   = cs_s & wr_s;
    rd_act   = cs_s & rd_s;
    wr_word  = h16_i | byte_hi_q;
    wr_push  = wr_act & ~done_q & ~hcfg_i & ~seq_first_q & ~wbuf_full & wr_word;
    wr_data  = h16_i ? had_i : {had_i[BYTE_W-1:0], lo_stage_q};
    rd_start = rd_act & ~done_q & ~hcfg_i & ~rbuf_valid_q & ~wbuf_full & ~rd_pend;
    cfg_val  = '0;
    cfg_val[CFG_LATE]    = ack_q.late;
    cfg_val[CFG_READY]   = ack_q.ready;
    cfg_val[CFG_POL]     = pol_q;
    cfg_val[CFG_ACCMODE] = acc_mode_q;
    cfg_val[CFG_AUTOINC] = autoinc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q       <= 1'b0;
      pol_q        <= 1'b0;
      ack_q        <= '0;
      acc_mode_q   <= 1'b0;
      autoinc_q    <= 1'b0;
      seq_first_q  <= 1'b0;
      done_q       <= 1'b0;
      acc_cfg_q    <= 1'b0;
      byte_hi_q    <= 1'b0;
      rbuf_valid_q <= 1'b0;
      lo_stage_q   <= '0;
      rbuf_q       <= '0;
      addr_q       <= '0;
    end else begin
      // straps are taken once, on the first clock out of reset
      if (!init_q) begin
        init_q      <= 1'b1;
        pol_q       <= strap_pol_i;
        ack_q.ready <= ~(strap_pol_i ^ strap_ack_i);
        ack_q.late  <= 1'b0;
      end
      if (cs_rise) seq_first_q <= 1'b1;
      if (rd_gnt) begin
        rbuf_q       <= mem_rdata_i;
        rbuf_valid_q <= 1'b1;
      end
      if (ale_rise) begin
        addr_q       <= had_i[ADDR_W-1:0];
        seq_first_q  <= 1'b0;
        acc_mode_q   <= 1'b0;
        byte_hi_q    <= 1'b0;
        rbuf_valid_q <= 1'b0;
      end
      if (wr_act && !done_q) begin
        if (hcfg_i) begin
          ack_q.late  <= had_i[CFG_LATE];
          ack_q.ready <= had_i[CFG_READY];
          autoinc_q   <= had_i[CFG_AUTOINC];
          done_q      <= 1'b1;
          acc_cfg_q   <= 1'b1;
        end else if (seq_first_q) begin
          // address cycle: first write of the sequence carries the address
          addr_q       <= had_i[ADDR_W-1:0];
          acc_mode_q   <= 1'b1;
          seq_first_q  <= 1'b0;
          byte_hi_q    <= 1'b0;
          rbuf_valid_q <= 1'b0;
          done_q       <= 1'b1;
          acc_cfg_q    <= 1'b1;
        end else if (!wbuf_full) begin
          done_q    <= 1'b1;
          acc_cfg_q <= 1'b0;
          if (wr_word) begin
            byte_hi_q <= 1'b0;
            if (autoinc_q) addr_q <= addr_q + 1'b1;
          end else begin
            lo_stage_q <= had_i[BYTE_W-1:0];
            byte_hi_q  <= 1'b1;
          end
        end
      end
      if (rd_act && !done_q) begin
        seq_first_q <= 1'b0;
        if (hcfg_i) begin
          rbuf_q       <= cfg_val;
          rbuf_valid_q <= 1'b0;
          byte_hi_q    <= 1'b0;
          done_q       <= 1'b1;
          acc_cfg_q    <= 1'b1;
        end else if (rbuf_valid_q && !wbuf_full) begin
          done_q    <= 1'b1;
          acc_cfg_q <= 1'b0;
        end
      end
      if (wr_fall) done_q <= 1'b0;
      if (rd_fall && done_q) begin
        done_q <= 1'b0;
        if (!acc_cfg_q) begin
          if (!h16_i && !byte_hi_q) begin
            byte_hi_q <= 1'b1;
          end else begin
            byte_hi_q    <= 1'b0;
            rbuf_valid_q <= 1'b0;
            if (autoinc_q) addr_q <= addr_q + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    had_o    = h16_i ? rbuf_q
                     : {{BYTE_W{1'b0}}, byte_hi_q ? rbuf_q[BUS_W-1:BYTE_W] : rbuf_q[BYTE_W-1:0]};
    had_oe_o = rd_act;
  end

  hport_mem_if #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) i_mem_if (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (wr_push),
    .push_addr_i(addr_q),
    .push_data_i(wr_data),
    .rd_start_i (rd_start),
    .rd_addr_i  (addr_q),
    .wbuf_full_o(wbuf_full),
    .rd_pend_o  (rd_pend),
    .rd_gnt_o   (rd_gnt),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_gnt_i  (mem_gnt_i)
  );

  hport_ack i_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pol_i       (pol_q),
    .ready_mode_i(ack_q.ready),
    .late_i      (ack_q.late),
    .strobe_i    (hcs_i & (hwr_i | hrd_i)),
    .done_i      (done_q),
    .hack_o      (hack_o)
  );
endmodule

// File: rtl/hport_chk.sv
module hport_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hcs_i,
  input logic              hwr_i,
  input logic              hrd_i,
  input logic              hcfg_i,
  input logic              hack_i,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [15:0]       mem_wdata_i,
  input logic              mem_gnt_i,
  input logic              init_i,
  input logic              pol_i,
  input logic              ready_i,
  input logic              push_i,
  input logic              wbuf_full_i,
  input logic              done_i,
  input logic              rd_act_i,
  input logic              rbuf_valid_i
);
  logic strobe;
  assign strobe = hcs_i & (hwr_i | hrd_i);

  assert_pol_fixed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && $past(init_i) |-> $stable(pol_i));

  assert_ack_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && !ready_i && !strobe |-> hack_i == !pol_i);

  assert_ready_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && ready_i && !strobe |-> hack_i == pol_i);

  assert_rd_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) && rd_act_i && !hcfg_i |-> rbuf_valid_i && !wbuf_full_i);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !wbuf_full_i);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_gnt_i |=> mem_req_i);

  assert_req_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_gnt_i |=> $stable(mem_addr_i) && $stable(mem_we_i) && $stable(mem_wdata_i));
endmodule

bind hport_slave hport_chk #(.ADDR_W(ADDR_W)) i_hport_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hcs_i       (hcs_i),
  .hwr_i       (hwr_i),
  .hrd_i       (hrd_i),
  .hcfg_i      (hcfg_i),
  .hack_i      (hack_o),
  .mem_req_i   (mem_req_o),
  .mem_we_i    (mem_we_o),
  .mem_addr_i  (mem_addr_o),
  .mem_wdata_i (mem_wdata_o),
  .mem_gnt_i   (mem_gnt_i),
  .init_i      (init_q),
  .pol_i       (pol_q),
  .ready_i     (ack_q.ready),
  .push_i      (wr_push),
  .wbuf_full_i (wbuf_full),
  .done_i      (done_q),
  .rd_act_i    (rd_act),
  .rbuf_valid_i(rbuf_valid_q)
);

// File: tb/test_hport_slave.sv
module test_hport_slave;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_pol = 1'b0, strap_ack = 1'b0;
  logic        hcs = 1'b0, hale = 1'b0, hwr = 1'b0, hrd = 1'b0, hcfg = 1'b0, h16 = 1'b1;
  logic [15:0] had = '0;
  logic [15:0] had_o;
  logic        had_oe, hack;
  logic        mem_req, mem_we, mem_gnt = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;

  logic [15:0] mem [256];
  int gnt_delay = 0, gcnt = 0, mcyc = 0;
  int pass_cnt = 0, fail_cnt = 0;
  logic pol_e = 1'b0;
  bit saw_wait = 1'b0;

  always #2 clk = ~clk;

  hport_slave i_hport_slave (
    .clk_i(clk), .rst_ni(rst_ni), .strap_pol_i(strap_pol), .strap_ack_i(strap_ack),
    .hcs_i(hcs), .hale_i(hale), .hwr_i(hwr), .hrd_i(hrd), .hcfg_i(hcfg), .h16_i(h16),
    .had_i(had), .had_o(had_o), .had_oe_o(had_oe), .hack_o(hack),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_gnt_i(mem_gnt)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 291) ^ 23130);
  endfunction

  always @(negedge clk) begin
    if (mem_gnt) mem_gnt = 1'b0;
    else if (mem_req) begin
      if (gcnt >= gnt_delay) begin
        mem_gnt = 1'b1;
        gcnt = 0;
        mcyc++;
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[7:0]];
      end else gcnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic p, input logic a);
    strap_pol = p; strap_ack = a; rst_ni = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    idle(4);
  endtask

  task automatic host_wait(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (hack !== pol_e) saw_wait = 1'b1;
    end while (hack !== pol_e && n < 400);
  endtask

  task automatic cs_on();  hcs = 1'b1; idle(4); endtask
  task automatic cs_off(); hcs = 1'b0; idle(4); endtask

  task automatic host_ale(input logic [15:0] a);
    had = a; hale = 1'b1; idle(4); hale = 1'b0; idle(4);
  endtask

  task automatic host_wr(input logic [15:0] d, input logic cfg, output int n);
    had = d; hcfg = cfg; hwr = 1'b1;
    host_wait(n);
    hwr = 1'b0; idle(6); hcfg = 1'b0;
  endtask

  task automatic host_rd(input logic cfg, output logic [15:0] d, output int n);
    hcfg = cfg; hrd = 1'b1;
    host_wait(n);
    d = had_o;
    hrd = 1'b0; idle(6); hcfg = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    fail_cnt++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n, n1, n2, m0;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);

    // R1/R2/R3: strap sweep
    for (int k = 0; k < 4; k++) begin
      logic p, a, b6;
      p = k[1]; a = k[0]; b6 = ~(p ^ a);
      pol_e = p;
      do_reset(p, a);
      if (b6) check(hack === p, "R3 ready idle level", int'(hack), int'(p));
      else    check(hack === ~p, "R2 ack idle level", int'(hack), int'(~p));
      cs_on();
      host_rd(1'b1, d, n);
      cs_off();
      check(d[7:5] == {1'b0, b6, p}, "R1 strap config", int'(d[7:5]), int'({1'b0, b6, p}));
    end
    strap_pol = 1'b0; strap_ack = 1'b1;
    idle(4);
    cs_on(); host_rd(1'b1, d, n); cs_off();
    check(d[7:5] == 3'b011, "R1 straps ignored after reset", int'(d[7:5]), 3);

    // pol 1, ACK mode
    pol_e = 1'b1;
    do_reset(1'b1, 1'b0);
    check(hack === 1'b0, "R2 ack idle after reset", int'(hack), 0);
    cs_on();
    m0 = mcyc;
    host_ale(16'h0010);
    host_wr(16'hBEEF, 1'b0, n);
    check(mem[16] == 16'hBEEF, "R6 ale write", int'(mem[16]), 'hBEEF);
    check(mcyc - m0 == 1, "R10 one cycle per write", mcyc - m0, 1);
    host_ale(16'h0033);
    m0 = mcyc;
    host_rd(1'b0, d, n);
    check(d == pat(51), "R6 ale read", int'(d), int'(pat(51)));
    host_rd(1'b0, d, n);
    check(d == pat(51), "R8 no increment when off", int'(d), int'(pat(51)));
    check(mcyc - m0 == 2, "R10 one cycle per read", mcyc - m0, 2);

    host_wr(16'h0001, 1'b1, n);
    host_ale(16'h0040);
    m0 = mcyc;
    for (int k = 0; k < 4; k++) host_wr(16'h1000 + 16'(k), 1'b0, n);
    for (int k = 0; k < 4; k++)
      check(mem[64 + k] == 16'h1000 + 16'(k), "R8 increment write", int'(mem[64 + k]), 'h1000 + k);
    check(mcyc - m0 == 4, "R10 burst cycles", mcyc - m0, 4);
    host_ale(16'h0050);
    for (int k = 0; k < 3; k++) begin
      host_rd(1'b0, d, n);
      check(d == pat(80 + k), "R8 increment read", int'(d), int'(pat(80 + k)));
    end
    cs_off();

    // R7: address cycle
    cs_on();
    host_wr(16'h0060, 1'b0, n);
    host_wr(16'hA1A1, 1'b0, n);
    host_wr(16'hA2A2, 1'b0, n);
    cs_off();
    check(mem[96] == 16'hA1A1, "R7 address cycle first", int'(mem[96]), 'hA1A1);
    check(mem[97] == 16'hA2A2, "R7 address cycle next", int'(mem[97]), 'hA2A2);
    cs_on(); host_rd(1'b1, d, n); cs_off();
    check(d == 16'h0031, "R7 mode bit set", int'(d), 'h31);
    cs_on();
    host_ale(16'h0061);
    host_rd(1'b0, d, n);
    check(d == 16'hA2A2, "R6 ale after address cycle", int'(d), 'hA2A2);
    host_rd(1'b1, d, n);
    check(d[4] == 1'b0, "R6 latch mode bit", int'(d[4]), 0);

    // R9: byte path
    h16 = 1'b0;
    host_ale(16'h0070);
    m0 = mcyc;
    host_wr(16'h0034, 1'b0, n);
    check(mcyc == m0, "R9 no write after low byte", mcyc - m0, 0);
    host_wr(16'h0012, 1'b0, n);
    check(mem[112] == 16'h1234, "R9 byte write", int'(mem[112]), 'h1234);
    host_ale(16'h0070);
    host_rd(1'b0, d, n);
    check(d == 16'h0034, "R9 low byte", int'(d), 'h34);
    host_rd(1'b0, d, n);
    check(d == 16'h0012, "R9 high byte", int'(d), 'h12);
    h16 = 1'b1;

    // R5 / R4: slow grant
    gnt_delay = 20;
    host_ale(16'h0080);
    host_wr(16'h1111, 1'b0, n1);
    host_wr(16'h2222, 1'b0, n2);
    check(n2 > n1 + 5, "R5 write held while buffer full", n2, n1 + 6);
    idle(40);
    check(mem[128] == 16'h1111 && mem[129] == 16'h2222, "R5 both writes land",
          int'(mem[129]), 'h2222);
    host_ale(16'h0090);
    host_rd(1'b0, d, n);
    check(n >= 20, "R4 read waits for grant", n, 20);
    check(d == pat(144), "R4 read data", int'(d), int'(pat(144)));
    gnt_delay = 0;

    // R11: config write mask and late acknowledge
    host_wr(16'h00FF, 1'b1, n);
    host_rd(1'b1, d, n1);
    check(d == 16'h00E1, "R11 read-only bits", int'(d), 'hE1);
    host_wr(16'h0041, 1'b1, n);
    host_rd(1'b1, d, n2);
    check(n1 == n2 + 1, "R11 late acknowledge", n1, n2 + 1);

    // R3: ready mode wait level
    check(hack === 1'b1, "R3 ready idle after write", int'(hack), 1);
    gnt_delay = 10;
    saw_wait = 1'b0;
    host_ale(16'h00A0);
    host_rd(1'b0, d, n);
    check(saw_wait && d == pat(160), "R3 not-ready while waiting", int'(saw_wait), 1);
    gnt_delay = 0;
    cs_off();

    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule